// File: doc/BRIEF.md
# Battery charge cycle controller

This block sequences one charge cycle of a nickel-chemistry battery charger. Analog comparators outside the block turn cell voltage and pack temperature into flags. A separate detector reports the slope- and peak-based termination events. From these the controller chooses the active phase: discharge-before-charge, charge pending, fast charge, top-off, pulse-trickle, charge complete, an over-voltage hold, or battery absent. It presents that phase, a discharge enable, and a charge-mode code to the current modulator.

A free-running prescaler produces a slow tick. A single safety counter runs off that tick. It limits fast charge, is cleared on the way into top-off, and then limits top-off as well. A second counter on the same tick times how long the cell voltage stays above the maximum. This tells a full battery (the voltage comes back down quickly) apart from a removed battery (the voltage stays high).

Top module: `chg_seq_top`

## Requirements
- R1: Phase codes are OFF=0, DISCH=1, PEND=2, FAST=3, TOPOFF=4, TRICKLE=5, DONE=6, ABSENT=7, OVHOLD=8. Charge-mode codes are off=0, fast=1, top-off=2, trickle=3. After reset the block shows phase 0, discharge enable 0 and mode 0.
- R2: A new cycle starts on a rising edge of `pwr_ok_i` or `inh_i`, with both inputs high. It also starts when `v_high_i` falls while the phase is ABSENT. The next phase is PEND if `dcmd_i` is high and DISCH if `dcmd_i` is low.
- R3: When either `pwr_ok_i` or `inh_i` is low, the next phase is OFF, with discharge enable 0 and mode 0. This check has the highest priority.
- R4: A falling edge on `dcmd_i` moves the block to DISCH from any phase. DISCH drives `dis_en_o`=1 and mode 0. DISCH ends when `v_low_i` is high, and the next phase is PEND.
- R5: PEND drives mode 3 and has no time limit. PEND moves to FAST only when `v_low_i`, `v_high_i` and `t_hot_i` are low and the cold condition is absent.
- R6: If `v_high_i` is high in PEND or DISCH, the next phase is ABSENT with mode 0. ABSENT holds until a new cycle starts.
- R7: If `v_high_i` is high in FAST, TOPOFF, TRICKLE or DONE, the next phase is OVHOLD with mode 0. If `v_high_i` drops before `MCV_TICKS` ticks have elapsed, the next phase is DONE. Otherwise the next phase is ABSENT.
- R8: FAST drives mode 1. FAST ends on any of: a termination flag, `t_cut_i`, the cold condition, or safety timer expiry. The next phase is TOPOFF if `topoff_en_i` is high and TRICKLE otherwise.
- R9: A tick occurs once every `TICK_DIV` cycles. The safety limit is `BASE_TICKS`·2^(4−`tmr_cfg_i`) ticks for codes 0 to 4 and `BASE_TICKS` for codes 5 to 7. The timer restarts on every phase change.
- R10: TOPOFF drives mode 2. TOPOFF ends only on `t_cut_i` or a full new safety period, and then goes to TRICKLE. The termination flags and the cold flag have no effect in TOPOFF.
- R11: TRICKLE and DONE drive mode 3 and have no time limit.
- R12: The cold condition is `t_cold_i` high with `pvd_sel_i` low. With `pvd_sel_i` high, `t_cold_i` neither blocks PEND nor ends FAST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Charging supply valid |
| inh_i | input | 1 | Charge enable; low suspends the block |
| dcmd_i | input | 1 | Discharge command, active low |
| v_low_i | input | 1 | Cell voltage below end-of-discharge |
| v_high_i | input | 1 | Cell voltage above maximum |
| t_cold_i | input | 1 | Temperature below the cold limit |
| t_hot_i | input | 1 | Temperature above the hot limit |
| t_cut_i | input | 1 | Temperature past the cutoff |
| pvd_sel_i | input | 1 | Peak-voltage termination selected |
| term_dtdt_i | input | 1 | Temperature-rate termination event |
| term_pvd_i | input | 1 | Peak-voltage termination event |
| term_ndv_i | input | 1 | Negative-delta-voltage termination event |
| topoff_en_i | input | 1 | Top-off phase enabled |
| tmr_cfg_i | input | 3 | Safety timer code |
| phase_o | output | 4 | Current phase code |
| dis_en_o | output | 1 | Discharge switch enable |
| chg_mode_o | output | 2 | Charge-mode select for the modulator |

## Verification
The bench covers the following corner cases:
- **Over-voltage hold.** The bench releases `v_high_i` just inside the window and also holds it past the window. A design that fixed the result on entry, or miscounted ticks, would report DONE where ABSENT is due, or the reverse.
- **Top-off.** The bench raises termination flags during TOPOFF. A design that left the safety counter running from fast charge would cut top-off short. A design that honoured the detector flags there would leave TOPOFF early.
- **Cold flag with peak-voltage selection.** The bench holds a cold battery while `pvd_sel_i` is high. A design that ignored this mode would stall in PEND.
- **Discharge command held low at inhibit release.** A design that needed an edge on `dcmd_i` would skip the discharge step.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [3:0] {
    PH_OFF     = 4'd0,
    PH_DISCH   = 4'd1,
    PH_PEND    = 4'd2,
    PH_FAST    = 4'd3,
    PH_TOPOFF  = 4'd4,
    PH_TRICKLE = 4'd5,
    PH_DONE    = 4'd6,
    PH_ABSENT  = 4'd7,
    PH_OVHOLD  = 4'd8
  } phase_e;

  typedef enum logic [1:0] {
    MD_OFF     = 2'd0,
    MD_FAST    = 2'd1,
    MD_TOPOFF  = 2'd2,
    MD_TRICKLE = 2'd3
  } mode_e;
endpackage

// File: rtl/chg_prescale.sv
module chg_prescale #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R9: ticks are spaced exactly TICK_DIV cycles apart
  p_tick_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/chg_win_cnt.sv
module chg_win_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         exp_o
);
  logic [W-1:0] cnt_q;

  assign exp_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (run_i && tick_i && !exp_o)   cnt_q <= cnt_q + 1'b1;
  end

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_advance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && run_i && tick_i && !exp_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
  p_hold_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwr_ok_i,
  input  logic   inh_i,
  input  logic   dcmd_i,
  input  logic   v_low_i,
  input  logic   v_high_i,
  input  logic   t_cold_i,
  input  logic   t_hot_i,
  input  logic   t_cut_i,
  input  logic   pvd_sel_i,
  input  logic   term_any_i,
  input  logic   topoff_en_i,
  input  logic   safe_exp_i,
  input  logic   win_exp_i,
  output phase_e phase_o,
  output logic   dis_en_o,
  output mode_e  mode_o,
  output logic   tmr_clr_o,
  output logic   safe_run_o,
  output logic   win_run_o
);
  phase_e st_q, st_d;
  logic   pwr_q, inh_q, dcmd_q, vhi_q;
  logic   dcmd_fall, start, cold, qual, stop_fast, active;

  assign active    = pwr_ok_i && inh_i;
  assign dcmd_fall = dcmd_q && !dcmd_i;
  assign start     = (pwr_ok_i && !pwr_q) || (inh_i && !inh_q) ||
                     ((st_q == PH_ABSENT) && vhi_q && !v_high_i);
  assign cold      = t_cold_i && !pvd_sel_i;
  assign qual      = !v_low_i && !v_high_i && !t_hot_i && !cold;
  assign stop_fast = term_any_i || t_cut_i || cold || safe_exp_i;

  always_comb begin
    st_d = st_q;
    if (!active)         st_d = PH_OFF;
    else if (dcmd_fall)  st_d = PH_DISCH;
    else if (start)      st_d = dcmd_i ? PH_PEND : PH_DISCH;
    else begin
      unique case (st_q)
        PH_DISCH:   if (v_high_i) st_d = PH_ABSENT;
                    else if (v_low_i) st_d = PH_PEND;
        PH_PEND:    if (v_high_i) st_d = PH_ABSENT;
                    else if (qual) st_d = PH_FAST;
        PH_FAST:    if (v_high_i) st_d = PH_OVHOLD;
                    else if (stop_fast) st_d = topoff_en_i ? PH_TOPOFF : PH_TRICKLE;
        PH_TOPOFF:  if (v_high_i) st_d = PH_OVHOLD;
                    else if (t_cut_i || safe_exp_i) st_d = PH_TRICKLE;
        PH_TRICKLE,
        PH_DONE:    if (v_high_i) st_d = PH_OVHOLD;
        PH_OVHOLD:  if (!v_high_i) st_d = PH_DONE;
                    else if (win_exp_i) st_d = PH_ABSENT;
        default:    st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_OFF;
      pwr_q  <= 1'b0;
      inh_q  <= 1'b0;
      dcmd_q <= 1'b1;
      vhi_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pwr_q  <= pwr_ok_i;
      inh_q  <= inh_i;
      dcmd_q <= dcmd_i;
      vhi_q  <= v_high_i;
    end
  end

  always_comb begin
    unique case (st_q)
      PH_FAST:                     mode_o = MD_FAST;
      PH_TOPOFF:                   mode_o = MD_TOPOFF;
      PH_PEND, PH_TRICKLE, PH_DONE: mode_o = MD_TRICKLE;
      default:                     mode_o = MD_OFF;
    endcase
  end

  assign phase_o    = st_q;
  assign dis_en_o   = (st_q == PH_DISCH);
  assign tmr_clr_o  = (st_d != st_q);
  assign safe_run_o = (st_q == PH_FAST) || (st_q == PH_TOPOFF);
  assign win_run_o  = (st_q == PH_OVHOLD);

  p_inhibit_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (st_q == PH_OFF));
  p_dcmd_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $fell(dcmd_i)) |=> (st_q == PH_DISCH));
  p_fast_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_FAST) && ($past(st_q) != PH_FAST)) |-> ($past(st_q) == PH_PEND));
  p_absent_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_ABSENT) && v_high_i && active && dcmd_i && dcmd_q && pwr_q && inh_q)
    |=> (st_q == PH_ABSENT));
  p_ovhold_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_FAST) && v_high_i && active && !dcmd_fall && !start) |=> (st_q == PH_OVHOLD));
  p_topoff_entry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == PH_TOPOFF) && ($past(st_q) != PH_TOPOFF)) |-> ($past(st_q) == PH_FAST));
endmodule

// File: rtl/chg_seq_top.sv
module chg_seq_top
  import chg_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned BASE_TICKS = 2,
  parameter int unsigned MCV_TICKS  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       inh_i,
  input  logic       dcmd_i,
  input  logic       v_low_i,
  input  logic       v_high_i,
  input  logic       t_cold_i,
  input  logic       t_hot_i,
  input  logic       t_cut_i,
  input  logic       pvd_sel_i,
  input  logic       term_dtdt_i,
  input  logic       term_pvd_i,
  input  logic       term_ndv_i,
  input  logic       topoff_en_i,
  input  logic [2:0] tmr_cfg_i,
  output logic [3:0] phase_o,
  output logic       dis_en_o,
  output logic [1:0] chg_mode_o
);
  localparam int unsigned SW = $clog2(BASE_TICKS * 16 + 1);
  localparam int unsigned MW = $clog2(MCV_TICKS + 1) + 1;
  localparam logic [SW-1:0] BASE = SW'(BASE_TICKS);

  logic          tick, tmr_clr, safe_run, win_run, safe_exp, win_exp;
  logic [SW-1:0] safe_lim;
  phase_e        phase;
  mode_e         mode;

  always_comb begin
    case (tmr_cfg_i)
      3'd0:    safe_lim = BASE << 4;
      3'd1:    safe_lim = BASE << 3;
      3'd2:    safe_lim = BASE << 2;
      3'd3:    safe_lim = BASE << 1;
      default: safe_lim = BASE;
    endcase
  end

  chg_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_o (tick)
  );

  chg_win_cnt #(.W(SW)) u_safe (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (tmr_clr), .run_i (safe_run),
    .tick_i (tick), .limit_i (safe_lim), .exp_o (safe_exp)
  );

  chg_win_cnt #(.W(MW)) u_ovwin (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (tmr_clr), .run_i (win_run),
    .tick_i (tick), .limit_i (MW'(MCV_TICKS)), .exp_o (win_exp)
  );

  chg_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_ok_i    (pwr_ok_i),
    .inh_i       (inh_i),
    .dcmd_i      (dcmd_i),
    .v_low_i     (v_low_i),
    .v_high_i    (v_high_i),
    .t_cold_i    (t_cold_i),
    .t_hot_i     (t_hot_i),
    .t_cut_i     (t_cut_i),
    .pvd_sel_i   (pvd_sel_i),
    .term_any_i  (term_dtdt_i || term_pvd_i || term_ndv_i),
    .topoff_en_i (topoff_en_i),
    .safe_exp_i  (safe_exp),
    .win_exp_i   (win_exp),
    .phase_o     (phase),
    .dis_en_o    (dis_en_o),
    .mode_o      (mode),
    .tmr_clr_o   (tmr_clr),
    .safe_run_o  (safe_run),
    .win_run_o   (win_run)
  );

  assign phase_o    = phase;
  assign chg_mode_o = mode;
endmodule

// File: tb/sim_chg_seq_top.sv
`timescale 1ns/1ps
module sim_chg_seq_top;
  localparam int DIV = 4, BASE = 2, MCV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwr = 0, inh = 0, dcmd = 1, vlo = 0, vhi = 0, cold = 0, hot = 0, cut = 0;
  logic pvd = 0, tdt = 0, tpv = 0, tnd = 0, topen = 0;
  logic [2:0] cfg = 3'd4;
  logic [3:0] phase;
  logic       dis;
  logic [1:0] mode;

  int unsigned vectors = 0, fails = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // model state
  int m_st, m_pc, m_sc, m_wc;
  bit m_pwr, m_inh, m_dcmd, m_vhi;

  always #2.5 clk = ~clk;

  chg_seq_top #(.TICK_DIV(DIV), .BASE_TICKS(BASE), .MCV_TICKS(MCV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr), .inh_i(inh), .dcmd_i(dcmd),
    .v_low_i(vlo), .v_high_i(vhi), .t_cold_i(cold), .t_hot_i(hot), .t_cut_i(cut),
    .pvd_sel_i(pvd), .term_dtdt_i(tdt), .term_pvd_i(tpv), .term_ndv_i(tnd),
    .topoff_en_i(topen), .tmr_cfg_i(cfg), .phase_o(phase), .dis_en_o(dis),
    .chg_mode_o(mode)
  );

  function automatic int exp_mode(int s);
    case (s)
      3: return 1;
      4: return 2;
      2, 5, 6: return 3;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, one step per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_sc = 0; m_wc = 0;
      m_pwr = 0; m_inh = 0; m_dcmd = 1; m_vhi = 0;
    end else begin
      int  lim, nx;
      bit  tick, sexp, wexp, coldc, strt;
      tick  = (m_pc == DIV - 1);
      lim   = (cfg <= 4) ? (BASE * (1 << (4 - cfg))) : BASE;
      sexp  = (m_sc >= lim);
      wexp  = (m_wc >= MCV);
      coldc = cold && !pvd;
      strt  = (pwr && !m_pwr) || (inh && !m_inh) || (m_st == 7 && m_vhi && !vhi);
      nx = m_st;
      if (!pwr || !inh) nx = 0;
      else if (m_dcmd && !dcmd) nx = 1;
      else if (strt) nx = dcmd ? 2 : 1;
      else if (m_st == 1) begin
        if (vhi) nx = 7; else if (vlo) nx = 2;
      end else if (m_st == 2) begin
        if (vhi) nx = 7; else if (!vlo && !hot && !coldc) nx = 3;
      end else if (m_st == 3) begin
        if (vhi) nx = 8;
        else if (tdt || tpv || tnd || cut || coldc || sexp) nx = topen ? 4 : 5;
      end else if (m_st == 4) begin
        if (vhi) nx = 8; else if (cut || sexp) nx = 5;
      end else if (m_st == 5 || m_st == 6) begin
        if (vhi) nx = 8;
      end else if (m_st == 8) begin
        if (!vhi) nx = 6; else if (wexp) nx = 7;
      end
      if (nx != m_st) begin
        m_sc = 0; m_wc = 0;
      end else begin
        if ((m_st == 3 || m_st == 4) && tick && !sexp) m_sc++;
        if (m_st == 8 && tick && !wexp) m_wc++;
      end
      m_pc  = tick ? 0 : m_pc + 1;
      m_st  = nx;
      m_pwr = pwr; m_inh = inh; m_dcmd = dcmd; m_vhi = vhi;
    end
  end

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !finished) begin
    vectors++;
    if (phase !== 4'(m_st) || dis !== (m_st == 1) || mode !== 2'(exp_mode(m_st))) begin
      fails++;
      $display("FAIL %s: phase/dis/mode actual %0d/%0d/%0d expected %0d/%0d/%0d",
               cur_req, phase, dis, mode, m_st, (m_st == 1), exp_mode(m_st));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ph(int ph, int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (m_st == ph) break;
      @(negedge clk);
    end
  endtask

  initial begin
    cyc(3);
    // R1: reset state visible before release
    vectors++;
    if (phase !== 4'd0 || dis !== 1'b0 || mode !== 2'd0) begin
      fails++;
      $display("FAIL R1: reset actual %0d/%0d/%0d expected 0/0/0", phase, dis, mode);
    end
    rst_n = 1;
    cyc(2);
    // R2 + R5: power up with low cell, stays pending
    cur_req = "R2"; vlo = 1; pwr = 1; inh = 1;
    cyc(2);
    cur_req = "R5"; cyc(10);
    vlo = 0; hot = 1; cyc(6);
    hot = 0; cold = 1; cyc(6);
    // R12: peak-voltage mode skips cold check
    cur_req = "R12"; pvd = 1; cyc(4);
    // R8 + R9: timer expiry ends fast charge, no top-off
    cur_req = "R9"; wait_ph(5, 200); cyc(4);
    cur_req = "R11"; cyc(40);
    // R4: discharge command pulse
    cur_req = "R4"; dcmd = 0; cyc(1); dcmd = 1; cyc(8);
    vlo = 1; cyc(3); vlo = 0; cold = 0; pvd = 0; cyc(3);
    // R8: detector flag ends fast, top-off enabled
    cur_req = "R8"; topen = 1; cfg = 3'd3; cyc(5);
    tnd = 1; cyc(2); tnd = 0;
    // R10: flags ignored in top-off, full period runs
    cur_req = "R10"; tdt = 1; tpv = 1; cold = 1; cyc(10);
    tdt = 0; tpv = 0; cold = 0;
    wait_ph(5, 200); cyc(3);
    // R7: short over-voltage gives DONE
    cur_req = "R7"; vhi = 1; cyc(2 * DIV); vhi = 0; cyc(4);
    // R7: long over-voltage gives ABSENT
    vhi = 1; cyc(DIV * (MCV + 3));
    cur_req = "R6"; cyc(10);
    // R2: battery replacement from absent
    cur_req = "R2"; vlo = 1; vhi = 0; cyc(4);
    // R6: over-voltage while pending
    cur_req = "R6"; vhi = 1; cyc(4); vhi = 0; cyc(3);
    // R3: inhibit and power loss
    cur_req = "R3"; inh = 0; cyc(4); dcmd = 0; cyc(2);
    // R2: held-low discharge command at inhibit release
    cur_req = "R2"; inh = 1; cyc(3); dcmd = 1; cyc(2);
    cur_req = "R4"; cyc(2); vlo = 0; cyc(3);
    // R9: longest timer code and an out-of-range code
    cur_req = "R9"; vlo = 1; pwr = 0; cyc(2); pwr = 1; cfg = 3'd0; topen = 0; cyc(2);
    vlo = 0; wait_ph(5, 300); cyc(3);
    cur_req = "R3"; pwr = 0; cyc(3); pwr = 1; cfg = 3'd7; cyc(2);
    cur_req = "R9"; wait_ph(5, 100); cyc(3);
    // R8: cutoff ends fast charge
    cur_req = "R8"; inh = 0; cyc(2); inh = 1; cyc(3); cfg = 3'd0; cyc(4); cut = 1; cyc(3); cut = 0; cyc(4);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule